// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides, in a single combinational pass, whether a load, a store or an instruction fetch may touch a page. It is given several inputs:

- the processor privilege state;
- the two segment key bits;
- the three-bit page protection code;
- the no-execute and guarded attributes of the page;
- the page's storage key;
- two 64-bit authority mask registers, one for data and one for instructions.

From these it produces the read, write and execute rights that remain, a violation flag for the requested access, and the fault status bits that an exception unit would record.

Three independent sources of permission are ANDed together:

- a key-dependent protection table;
- a filter that removes execute rights from no-execute or guarded pages;
- a per-storage-key authority mask.

Fault status is then composed from whichever sources denied the access, with a fixed priority for fetches. The block sits between the page table walker and the exception sequencer, and it handles neither of those jobs.

Top module: `perm_eval`

## Requirements
- R1: The effective key is `key_user_i` when `problem_state_i` is 1 and `key_super_i` when it is 0.
- R2: The protection code is `{pp_hi_i, pp_lo_i[1:0]}`. With effective key 0, codes 0, 1 and 2 grant read, write and execute; codes 3 and 6 grant read and execute; codes 4, 5 and 7 grant nothing.
- R3: With effective key 1, codes 1 and 3 grant read and execute, and code 2 grants read, write and execute. Codes 0, 4, 5, 6 and 7 grant nothing.
- R4: When `noexec_i` or `guard_i` is 1, execute permission is removed. Read and write are unaffected by these two inputs.
- R5: For storage key k, the pair of bits examined in a mask register is bits [2*(31-k)+1 : 2*(31-k)]. In `amr_i` the upper bit of the pair removes write and the lower bit removes read. In `iamr_i` the lower bit removes execute.
- R6: `amr_i` is honoured only when `amask_en_i` is 1. `iamr_i` is honoured only when `amask_en_i` is 1 and `mmu_ver_i` is 2 or 3. Otherwise the mask registers have no effect on any output.
- R7: `perm_r_o`, `perm_w_o` and `perm_x_o` are the AND of the table grant, the execute filter and the mask grant.
- R8: `access_i` encodes the access as 0 for load, 1 for store and 2 for fetch, with 3 treated as a load. `violation_o` is 1 exactly when the permission that the access needs is absent from the final result.
- R9: On a fetch violation, `flt_nx_o` is 1 if the execute filter blocked. Otherwise `flt_prot_o` is 1 if the table withheld execute. `flt_amask_o` is 1 independently whenever the instruction mask withheld execute.
- R10: On a load or store violation, `flt_prot_o` is 1 if the table withheld the needed right, `flt_amask_o` is 1 if the data mask withheld it, and `flt_store_o` is 1 for a store. All fault bits are 0 when there is no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| problem_state_i | input | 1 | 1 for user (problem) state |
| key_user_i | input | 1 | Segment key used in user state |
| key_super_i | input | 1 | Segment key used in supervisor state |
| pp_hi_i | input | 1 | High bit of the protection code |
| pp_lo_i | input | 2 | Low two bits of the protection code |
| noexec_i | input | 1 | Page no-execute attribute |
| guard_i | input | 1 | Page guarded attribute |
| skey_i | input | 5 | Page storage key |
| amr_i | input | 64 | Data authority mask |
| iamr_i | input | 64 | Instruction authority mask |
| amask_en_i | input | 1 | Authority mask feature enable |
| mmu_ver_i | input | 2 | Translation model version, 2 and 3 are the newest |
| access_i | input | 2 | Requested access type |
| perm_r_o | output | 1 | Final read permission |
| perm_w_o | output | 1 | Final write permission |
| perm_x_o | output | 1 | Final execute permission |
| violation_o | output | 1 | Requested access is not permitted |
| flt_nx_o | output | 1 | Fetch blocked by no-execute or guard |
| flt_prot_o | output | 1 | Protection table withheld the access |
| flt_store_o | output | 1 | Violating access was a store |
| flt_amask_o | output | 1 | Authority mask withheld the access |

## Verification
The hardest situation to reach is a fetch in which several sources deny execute at once: the filter, the table and the instruction mask. Only that situation shows that the no-execute fault suppresses the protection fault while the mask fault still rides alongside it. Mask-pair placement is similarly subtle, since a wrong shift only shows when the pair for the chosen key differs from its neighbours. The stimulus sweeps every privilege, key, code, attribute and access combination against one-hot and walking mask patterns. It then applies a long stream of random vectors across model versions and enable settings, so that every combination of stacked denials occurs many times.

// File: rtl/perm_pkg.sv
package perm_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;

  localparam perm_t PERM_NONE = '{r: 1'b0, w: 1'b0, x: 1'b0};
  localparam perm_t PERM_RX   = '{r: 1'b1, w: 1'b0, x: 1'b1};
  localparam perm_t PERM_RWX  = '{r: 1'b1, w: 1'b1, x: 1'b1};
endpackage

// File: rtl/key_prot_table.sv
module key_prot_table
  import perm_pkg::*;
(
  input  logic       key_i,
  input  logic [2:0] code_i,
  output perm_t      grant_o
);
  always_comb begin
    grant_o = PERM_NONE;
    if (!key_i) begin
      unique case (code_i)
        3'd0, 3'd1, 3'd2: grant_o = PERM_RWX;
        3'd3, 3'd6:       grant_o = PERM_RX;
        default:          grant_o = PERM_NONE;
      endcase
    end else begin
      unique case (code_i)
        3'd1, 3'd3: grant_o = PERM_RX;
        3'd2:       grant_o = PERM_RWX;
        default:    grant_o = PERM_NONE;
      endcase
    end
  end

  always_comb begin
    if (key_i && (code_i == 3'd0 || code_i == 3'd6))
      AST_KEY1_NO_GRANT: assert (grant_o == PERM_NONE); // R3
    if (!key_i && code_i[2] && !code_i[1])
      AST_KEY0_HOLE_NO_GRANT: assert (grant_o == PERM_NONE); // R2
  end
endmodule

// File: rtl/amask_lookup.sv
module amask_lookup #(
  parameter int MASK_W = 64,
  localparam int KEYS  = MASK_W / 2,
  localparam int KEY_W = $clog2(KEYS)
) (
  input  logic [MASK_W-1:0] mask_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic [1:0]        pair_o
);
  logic [1:0] pairs [KEYS];

  // key 0 owns the most significant pair
  for (genvar k = 0; k < KEYS; k++) begin : g_pair
    assign pairs[k] = mask_i[2*(KEYS-1-k) +: 2];
  end

  assign pair_o = pairs[key_i];

  always_comb begin
    if (mask_i == '0)
      AST_ZERO_MASK_NO_DENY: assert (pair_o == 2'b00); // R5
  end
endmodule

// File: rtl/fault_compose.sv
module fault_compose
  import perm_pkg::*;
(
  input  logic [1:0] access_i,
  input  perm_t      tbl_i,
  input  logic       nxg_i,
  input  perm_t      mask_i,
  input  perm_t      final_i,
  output logic       violation_o,
  output logic       flt_nx_o,
  output logic       flt_prot_o,
  output logic       flt_store_o,
  output logic       flt_amask_o
);
  always_comb begin
    violation_o = 1'b0;
    flt_nx_o    = 1'b0;
    flt_prot_o  = 1'b0;
    flt_store_o = 1'b0;
    flt_amask_o = 1'b0;
    unique case (access_e'(access_i))
      ACC_FETCH: begin
        violation_o = !final_i.x;
        flt_nx_o    = violation_o && nxg_i;
        flt_prot_o  = violation_o && !nxg_i && !tbl_i.x;
        flt_amask_o = violation_o && !mask_i.x;
      end
      ACC_STORE: begin
        violation_o = !final_i.w;
        flt_prot_o  = violation_o && !tbl_i.w;
        flt_store_o = violation_o;
        flt_amask_o = violation_o && !mask_i.w;
      end
      default: begin
        violation_o = !final_i.r;
        flt_prot_o  = violation_o && !tbl_i.r;
        flt_amask_o = violation_o && !mask_i.r;
      end
    endcase
  end

  always_comb begin
    if (flt_nx_o || flt_prot_o || flt_store_o || flt_amask_o)
      AST_FAULT_NEEDS_VIOL: assert (violation_o); // R10
    if (flt_nx_o)
      AST_NX_OVER_PROT: assert (!flt_prot_o); // R9
    if (flt_store_o)
      AST_STORE_FLAG_ONLY_STORE: assert (access_i == 2'd1); // R10
  end
endmodule

// File: rtl/perm_eval.sv
module perm_eval
  import perm_pkg::*;
#(
  parameter int MASK_W = 64,
  localparam int KEY_W = $clog2(MASK_W / 2)
) (
  input  logic              problem_state_i,
  input  logic              key_user_i,
  input  logic              key_super_i,
  input  logic              pp_hi_i,
  input  logic [1:0]        pp_lo_i,
  input  logic              noexec_i,
  input  logic              guard_i,
  input  logic [KEY_W-1:0]  skey_i,
  input  logic [MASK_W-1:0] amr_i,
  input  logic [MASK_W-1:0] iamr_i,
  input  logic              amask_en_i,
  input  logic [1:0]        mmu_ver_i,
  input  logic [1:0]        access_i,
  output logic              perm_r_o,
  output logic              perm_w_o,
  output logic              perm_x_o,
  output logic              violation_o,
  output logic              flt_nx_o,
  output logic              flt_prot_o,
  output logic              flt_store_o,
  output logic              flt_amask_o
);
  logic       eff_key;
  logic       nxg;
  logic       use_dmask, use_imask;
  logic [1:0] dpair, ipair;
  perm_t      tbl, mask_grant, final_grant;

  assign eff_key = problem_state_i ? key_user_i : key_super_i;
  assign nxg     = noexec_i | guard_i;

  key_prot_table u_table (
    .key_i   (eff_key),
    .code_i  ({pp_hi_i, pp_lo_i}),
    .grant_o (tbl)
  );

  amask_lookup #(.MASK_W(MASK_W)) u_dmask (
    .mask_i (amr_i),
    .key_i  (skey_i),
    .pair_o (dpair)
  );

  amask_lookup #(.MASK_W(MASK_W)) u_imask (
    .mask_i (iamr_i),
    .key_i  (skey_i),
    .pair_o (ipair)
  );

  assign use_dmask = amask_en_i;
  assign use_imask = amask_en_i && mmu_ver_i[1];

  assign mask_grant.r = !(use_dmask && dpair[0]);
  assign mask_grant.w = !(use_dmask && dpair[1]);
  assign mask_grant.x = !(use_imask && ipair[0]);

  assign final_grant.r = tbl.r & mask_grant.r;
  assign final_grant.w = tbl.w & mask_grant.w;
  assign final_grant.x = tbl.x & mask_grant.x & !nxg;

  assign perm_r_o = final_grant.r;
  assign perm_w_o = final_grant.w;
  assign perm_x_o = final_grant.x;

  fault_compose u_fault (
    .access_i    (access_i),
    .tbl_i       (tbl),
    .nxg_i       (nxg),
    .mask_i      (mask_grant),
    .final_i     (final_grant),
    .violation_o (violation_o),
    .flt_nx_o    (flt_nx_o),
    .flt_prot_o  (flt_prot_o),
    .flt_store_o (flt_store_o),
    .flt_amask_o (flt_amask_o)
  );

  always_comb begin
    if (noexec_i || guard_i)
      AST_NXG_NO_EXEC: assert (!perm_x_o); // R4
    if (!amask_en_i)
      AST_MASK_OFF_NO_AMASK_FAULT: assert (!flt_amask_o); // R6
    if (perm_w_o)
      AST_WRITE_NEEDS_TABLE: assert (tbl.w); // R7
    if (access_i == 2'd2 && perm_x_o)
      AST_FETCH_OK_NO_VIOL: assert (!violation_o); // R8
  end
endmodule

// File: tb/tb_perm_eval.sv
module tb_perm_eval;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic        problem_state, key_user, key_super, pp_hi, noexec, guard;
  logic [1:0]  pp_lo, mmu_ver, access;
  logic [4:0]  skey;
  logic [63:0] amr, iamr;
  logic        amask_en;
  logic        pr, pw, px, viol, fnx, fprot, fst, fam;

  perm_eval dut (
    .problem_state_i (problem_state),
    .key_user_i      (key_user),
    .key_super_i     (key_super),
    .pp_hi_i         (pp_hi),
    .pp_lo_i         (pp_lo),
    .noexec_i        (noexec),
    .guard_i         (guard),
    .skey_i          (skey),
    .amr_i           (amr),
    .iamr_i          (iamr),
    .amask_en_i      (amask_en),
    .mmu_ver_i       (mmu_ver),
    .access_i        (access),
    .perm_r_o        (pr),
    .perm_w_o        (pw),
    .perm_x_o        (px),
    .violation_o     (viol),
    .flt_nx_o        (fnx),
    .flt_prot_o      (fprot),
    .flt_store_o     (fst),
    .flt_amask_o     (fam)
  );

  typedef struct packed {
    logic [7:0] bits; // r w x viol nx prot store amask
    logic [3:0] req;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  logic done   = 1'b0;

  // expected result built from the requirement text
  function automatic logic [7:0] model(
    logic ps, logic ku, logic ks, logic [2:0] code, logic nx, logic g,
    logic [4:0] k, logic [63:0] dm, logic [63:0] im, logic en,
    logic [1:0] ver, logic [1:0] acc);
    logic key, tr, tw, tx, mr, mw, mx, fr, fw, fx, nxg, v, f_nx, f_pr, f_st, f_am;
    int sh;
    key = ps ? ku : ks;                                      // R1
    tr = 0; tw = 0; tx = 0;
    if (!key) begin                                          // R2
      if (code <= 3'd2) begin tr = 1; tw = 1; tx = 1; end
      else if (code == 3'd3 || code == 3'd6) begin tr = 1; tx = 1; end
    end else begin                                           // R3
      if (code == 3'd2) begin tr = 1; tw = 1; tx = 1; end
      else if (code == 3'd1 || code == 3'd3) begin tr = 1; tx = 1; end
    end
    sh = 2 * (31 - int'(k));                                 // R5
    mr = !(en && dm[sh]);
    mw = !(en && dm[sh+1]);
    mx = !(en && ver >= 2'd2 && im[sh]);                     // R6
    nxg = nx | g;                                            // R4
    fr = tr & mr; fw = tw & mw; fx = tx & mx & !nxg;         // R7
    f_nx = 0; f_pr = 0; f_st = 0; f_am = 0;
    if (acc == 2'd2) begin                                   // R9
      v = !fx;
      if (v) begin
        if (nxg) f_nx = 1; else if (!tx) f_pr = 1;
        f_am = !mx;
      end
    end else if (acc == 2'd1) begin                          // R10
      v = !fw;
      if (v) begin f_pr = !tw; f_st = 1; f_am = !mw; end
    end else begin                                           // R8: 3 acts as load
      v = !fr;
      if (v) begin f_pr = !tr; f_am = !mr; end
    end
    return {fr, fw, fx, v, f_nx, f_pr, f_st, f_am};
  endfunction

  task automatic drive(logic ps, logic ku, logic ks, logic [2:0] code,
                       logic nx, logic g, logic [4:0] k, logic [63:0] dm,
                       logic [63:0] im, logic en, logic [1:0] ver,
                       logic [1:0] acc, logic [3:0] req);
    exp_t e;
    @(negedge clk);
    problem_state = ps; key_user = ku; key_super = ks;
    {pp_hi, pp_lo} = code; noexec = nx; guard = g; skey = k;
    amr = dm; iamr = im; amask_en = en; mmu_ver = ver; access = acc;
    e.bits = model(ps, ku, ks, code, nx, g, k, dm, im, en, ver, acc);
    e.req  = req;
    exp_q.push_back(e);
  endtask

  // monitor: compare one cycle-aligned result per drive
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if ({pr, pw, px, viol, fnx, fprot, fst, fam} !== e.bits) begin
        n_fail++;
        $display("FAIL R%0d: got %b expected %b", e.req,
                 {pr, pw, px, viol, fnx, fprot, fst, fam}, e.bits);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    problem_state = 0; key_user = 0; key_super = 0; pp_hi = 0; pp_lo = 0;
    noexec = 0; guard = 0; skey = 0; amr = 0; iamr = 0; amask_en = 0;
    mmu_ver = 0; access = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // all-zero inputs: key 0 code 0 load, full rights (R2)
    drive(0, 0, 0, 3'd0, 0, 0, 5'd0, '0, '0, 0, 2'd0, 2'd0, 4'd2);
    // R1: user state picks user key -> key 1 code 0 denies load
    drive(1, 1, 0, 3'd0, 0, 0, 5'd0, '0, '0, 0, 2'd0, 2'd0, 4'd1);
    // R1: supervisor state picks supervisor key -> key 0 allows
    drive(0, 1, 0, 3'd0, 0, 0, 5'd0, '0, '0, 0, 2'd0, 2'd0, 4'd1);
    // R3: key 1 code 2 store allowed, code 3 store denied
    drive(0, 0, 1, 3'd2, 0, 0, 5'd0, '0, '0, 0, 2'd0, 2'd1, 4'd3);
    drive(0, 0, 1, 3'd3, 0, 0, 5'd0, '0, '0, 0, 2'd0, 2'd1, 4'd3);
    // R4: guarded fetch faults via nx, load still fine
    drive(0, 0, 0, 3'd0, 0, 1, 5'd0, '0, '0, 0, 2'd0, 2'd2, 4'd4);
    drive(0, 0, 0, 3'd0, 1, 0, 5'd0, '0, '0, 0, 2'd0, 2'd0, 4'd4);
    // R5: key 31 uses bits [1:0]; key 0 uses bits [63:62]
    drive(0, 0, 0, 3'd0, 0, 0, 5'd31, 64'h2, '0, 1, 2'd0, 2'd1, 4'd5);
    drive(0, 0, 0, 3'd0, 0, 0, 5'd0, 64'h1, '0, 1, 2'd0, 2'd1, 4'd5);
    drive(0, 0, 0, 3'd0, 0, 0, 5'd0, 64'h4000_0000_0000_0000, '0, 1, 2'd0, 2'd0, 4'd5);
    // R6: masks ignored when disabled, imask ignored on old version
    drive(0, 0, 0, 3'd0, 0, 0, 5'd3, '1, '1, 0, 2'd3, 2'd2, 4'd6);
    drive(0, 0, 0, 3'd0, 0, 0, 5'd3, '0, '1, 1, 2'd1, 2'd2, 4'd6);
    drive(0, 0, 0, 3'd0, 0, 0, 5'd3, '0, '1, 1, 2'd2, 2'd2, 4'd6);
    // R9: nx + table + imask all deny a fetch
    drive(0, 0, 1, 3'd0, 1, 0, 5'd7, '0, '1, 1, 2'd3, 2'd2, 4'd9);
    // R8: access code 3 behaves as load
    drive(0, 0, 1, 3'd0, 0, 0, 5'd0, '0, '0, 0, 2'd0, 2'd3, 4'd8);
    // R10: store denied by table and data mask together
    drive(1, 1, 0, 3'd1, 0, 0, 5'd9, '1, '0, 1, 2'd0, 2'd1, 4'd10);

    // R7: sweep of key, code, attributes and access with walking masks
    for (int ps = 0; ps < 2; ps++)
      for (int kk = 0; kk < 4; kk++)
        for (int c = 0; c < 8; c++)
          for (int a = 0; a < 4; a++)
            for (int ng = 0; ng < 4; ng++) begin
              logic [4:0] k;
              k = 5'(c * 4 + ng);
              drive(ps[0], kk[0], kk[1], 3'(c), ng[0], ng[1], k,
                    64'h9 << (2 * (31 - int'(k))), 64'hA5A5_5A5A_3C3C_C3C3,
                    1'b1, 2'(a), 2'(a), 4'd7);
            end

    // R7: random stream
    for (int i = 0; i < 3000; i++) begin
      drive($urandom % 2 == 1, $urandom % 2 == 1, $urandom % 2 == 1,
            3'($urandom), $urandom % 4 == 0, $urandom % 4 == 0, 5'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom}, $urandom % 2 == 1,
            2'($urandom), 2'($urandom), 4'd7);
    end

    while (exp_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule